// File: doc/BRIEF.md
# I2C Target Address Matcher and Transceiver

This block is the target (device) side of a two-wire serial bus. It watches the clock and data lines, finds START and STOP conditions, and shifts in the first byte after each START. The upper seven bits of that byte are compared against two configurable own addresses and, when enabled, against the all-zero broadcast address. On a hit the block acknowledges. The lowest bit of the byte then selects the direction. If it is 0, the block receives data bytes and hands each one to local logic through a one-byte receive holding register. If it is 1, the block sends bytes taken from a one-byte transmit holding register.

Both bus lines are modelled as open-drain. The block reads the resolved line levels and drives only pull-low enables. While local logic has not yet serviced a holding register, the block can keep SCL low at a byte boundary. A static control turns this clock stretching off. Status outputs report the following: a completed address match, which own address matched, a broadcast match, the transfer direction, receive-register full, transmit-register empty, a one-cycle pulse for a STOP ending an addressed transfer, and a one-cycle pulse for a START or STOP at an illegal point.

Top module: `i2c_target_port`

## Requirements
- R1: A START is a high-to-low SDA change while SCL is high, and a STOP is a low-to-high SDA change while SCL is high. Both lines pass through two synchronising flip-flops before detection. Every START clears addr_hit, hit_second, gen_call and dir_tx, and restarts address reception.
- R2: An address equal to own_addr_a or own_addr_b is acknowledged by pulling SDA low during the ninth clock, and addr_hit is set. hit_second reads 0 for a match on own_addr_a (which has priority) and 1 for a match on own_addr_b.
- R3: Address 0000000 is acknowledged only when gc_enable is 1. In that case gen_call reads 1. When gc_enable is 0, the address is not acknowledged.
- R4: A non-matching address is not acknowledged. The block then keeps SDA released and does not load rx_data for any further bytes until the next START.
- R5: After a match, dir_tx equals bit 0 of the address byte: 1 means the block transmits and 0 means it receives.
- R6: In receive mode, data bits are sampled while SCL is high, with the MSB first. The completed byte appears on rx_data with rx_full set to 1, and the block pulls SDA low during that byte's acknowledge clock. A one-cycle rx_read pulse clears rx_full.
- R7: In transmit mode, a tx_write pulse loads tx_data and clears tx_empty. The held byte is sent MSB first and tx_empty returns to 1 once the byte is taken. SDA is released during the master's acknowledge clock.
- R8: In transmit mode, if SDA is high during the master's acknowledge clock, the transfer ends. SDA stays released (bits read back as 1) until STOP or START.
- R9: With no_stretch at 0, the block holds SCL low in two cases: at a transmit byte boundary while tx_empty is 1, and after the eighth bit of a received byte while rx_full is still 1. The hold lasts until the register is serviced. With no_stretch at 1, the block never pulls SCL low, and an unread received byte is overwritten.
- R10: A STOP during an addressed transfer, at a legal position (after an acknowledge or after a terminating NACK), produces a one-cycle stop_seen pulse.
- R11: A START or STOP during an acknowledge clock, or after the second or a later bit of a byte has been clocked, produces a one-cycle bus_err pulse and no stop_seen.
- R12: After reset, both pull-low outputs are 0, tx_empty is 1, and rx_full, addr_hit, hit_second, gen_call, dir_tx, stop_seen and bus_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull | output | 1 | 1 pulls SDA low |
| own_addr_a | input | 7 | First own address |
| own_addr_b | input | 7 | Second own address |
| gc_enable | input | 1 | Respond to the broadcast address |
| no_stretch | input | 1 | 1 disables clock stretching |
| tx_data | input | 8 | Byte to transmit |
| tx_write | input | 1 | Load tx_data into the transmit holding register |
| tx_empty | output | 1 | Transmit holding register is empty |
| rx_data | output | 8 | Last received data byte |
| rx_full | output | 1 | rx_data holds an unread byte |
| rx_read | input | 1 | Marks rx_data as consumed |
| addr_hit | output | 1 | The current transfer addressed this block |
| hit_second | output | 1 | The match came from own_addr_b |
| gen_call | output | 1 | The match was the broadcast address |
| dir_tx | output | 1 | 1 means the block transmits |
| stop_seen | output | 1 | One-cycle pulse on a STOP ending an addressed transfer |
| bus_err | output | 1 | One-cycle pulse on a misplaced START or STOP |

## Verification
The bound checker covers the relations that must hold on every cycle:
- SDA is pulled low only inside an addressed transfer.
- Second-address and broadcast flags appear only together with a match, and never both at once.
- No SCL hold exists while stretching is disabled, and SDA is free when a hold begins.
- rx_full rises only in receive mode.
- stop_seen and bus_err never coincide.
- The state just after reset is as stated.

The bench scenarios show what no single-cycle property captures: the bit order of received and sent bytes, the address decision for each own address and for the broadcast address with the enable on and off, the idle behaviour after a miss or a NACK, the length and release of a hold, the overwrite without stretching, and the classification of a START or STOP by its position within the byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RXLD,
    ST_RACK,
    ST_TXLD,
    ST_TX,
    ST_TACK,
    ST_PARK
  } tgt_state_e;

  typedef struct packed {
    logic hit;
    logic second;
    logic gcall;
  } match_t;

endpackage

// File: rtl/i2ct_line_mon.sv
module i2ct_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2ct_addr_match.sv
module i2ct_addr_match
  import i2ct_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] rx_addr,
  input  logic [AW-1:0] own_a,
  input  logic [AW-1:0] own_b,
  input  logic          gc_en,
  output match_t        m
);

  logic zero_addr;
  logic eq_a;
  logic eq_b;

  always_comb begin
    zero_addr = (rx_addr == '0);
    eq_a      = ~zero_addr & (rx_addr == own_a);
    eq_b      = ~zero_addr & (rx_addr == own_b);
    m.gcall   = zero_addr & gc_en;
    m.second  = eq_b & ~eq_a;
    m.hit     = m.gcall | eq_a | eq_b;
  end

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic          sda_s,
  input  match_t        m,
  input  logic          no_stretch,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_write,
  input  logic          rx_read,
  output logic [AW-1:0] addr_field,
  output logic          sda_pull,
  output logic          scl_pull,
  output logic          tx_empty,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          addr_hit,
  output logic          hit_second,
  output logic          gen_call,
  output logic          dir_tx,
  output logic          stop_seen,
  output logic          bus_err
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);
  localparam logic [CW-1:0] EARLY_LIM = CW'(2);

  tgt_state_e    state;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] shtx;
  logic [DW-1:0] txbuf;
  logic          mack;
  logic          misplaced;

  assign addr_field = shreg[AW:1];

  // A condition is misplaced inside an acknowledge clock or after bit 2 of a byte
  always_comb begin
    case (state)
      ST_ADDR, ST_RX, ST_TX:    misplaced = (bitcnt >= EARLY_LIM);
      ST_AACK, ST_RACK, ST_TACK: misplaced = 1'b1;
      default:                   misplaced = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      shtx       <= '0;
      txbuf      <= '0;
      mack       <= 1'b0;
      sda_pull   <= 1'b0;
      scl_pull   <= 1'b0;
      tx_empty   <= 1'b1;
      rx_data    <= '0;
      rx_full    <= 1'b0;
      addr_hit   <= 1'b0;
      hit_second <= 1'b0;
      gen_call   <= 1'b0;
      dir_tx     <= 1'b0;
      stop_seen  <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      stop_seen <= 1'b0;
      bus_err   <= 1'b0;
      if (rx_read) rx_full <= 1'b0;

      if (start_c || stop_c) begin
        if (misplaced) bus_err <= 1'b1;
        else if (stop_c && addr_hit && state != ST_IDLE) stop_seen <= 1'b1;
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
        bitcnt   <= '0;
        if (start_c) begin
          state      <= ST_ADDR;
          addr_hit   <= 1'b0;
          hit_second <= 1'b0;
          gen_call   <= 1'b0;
          dir_tx     <= 1'b0;
        end else begin
          state <= ST_IDLE;
        end
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (m.hit) begin
                sda_pull   <= 1'b1;
                addr_hit   <= 1'b1;
                hit_second <= m.second;
                gen_call   <= m.gcall;
                dir_tx     <= shreg[0];
                state      <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              state    <= dir_tx ? ST_TXLD : ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              state <= ST_RXLD;
            end
          end
          ST_RXLD: begin
            if (!rx_full || no_stretch) begin
              rx_data  <= shreg;
              rx_full  <= 1'b1;
              sda_pull <= 1'b1;
              state    <= ST_RACK;
            end else begin
              scl_pull <= 1'b1;
            end
          end
          ST_RACK: begin
            // SDA settles one cycle before the clock hold is let go
            if (scl_pull) scl_pull <= 1'b0;
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_RX;
            end
          end
          ST_TXLD: begin
            if (!tx_empty || no_stretch) begin
              shtx     <= txbuf;
              sda_pull <= ~txbuf[DW-1];
              tx_empty <= 1'b1;
              bitcnt   <= '0;
              state    <= ST_TX;
            end else begin
              scl_pull <= 1'b1;
            end
          end
          ST_TX: begin
            if (scl_pull) scl_pull <= 1'b0;
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_pull <= 1'b0;
                state    <= ST_TACK;
              end else if (bitcnt != '0) begin
                sda_pull <= ~shtx[DW-2];
                shtx     <= shtx << 1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              state  <= mack ? ST_TXLD : ST_PARK;
            end
          end
          default: ;
        endcase
      end

      if (tx_write) begin
        txbuf    <= tx_data;
        tx_empty <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_target_port.sv
module i2c_target_port
  import i2ct_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_pull,
  output logic          sda_pull,
  input  logic [AW-1:0] own_addr_a,
  input  logic [AW-1:0] own_addr_b,
  input  logic          gc_enable,
  input  logic          no_stretch,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_write,
  output logic          tx_empty,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  input  logic          rx_read,
  output logic          addr_hit,
  output logic          hit_second,
  output logic          gen_call,
  output logic          dir_tx,
  output logic          stop_seen,
  output logic          bus_err
);

  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_c;
  logic          stop_c;
  logic [AW-1:0] addr_field;
  match_t        m;

  i2ct_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst      (rst),
    .scl_raw  (scl_in),
    .sda_raw  (sda_in),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2ct_addr_match #(.AW(AW)) u_match (
    .rx_addr (addr_field),
    .own_a   (own_addr_a),
    .own_b   (own_addr_b),
    .gc_en   (gc_enable),
    .m       (m)
  );

  i2ct_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_c    (start_c),
    .stop_c     (stop_c),
    .sda_s      (sda_s),
    .m          (m),
    .no_stretch (no_stretch),
    .tx_data    (tx_data),
    .tx_write   (tx_write),
    .rx_read    (rx_read),
    .addr_field (addr_field),
    .sda_pull   (sda_pull),
    .scl_pull   (scl_pull),
    .tx_empty   (tx_empty),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .addr_hit   (addr_hit),
    .hit_second (hit_second),
    .gen_call   (gen_call),
    .dir_tx     (dir_tx),
    .stop_seen  (stop_seen),
    .bus_err    (bus_err)
  );

endmodule

// File: rtl/i2c_target_port_chk.sv
module i2c_target_port_chk (
  input logic clk,
  input logic rst,
  input logic scl_pull,
  input logic sda_pull,
  input logic no_stretch,
  input logic tx_empty,
  input logic rx_full,
  input logic addr_hit,
  input logic hit_second,
  input logic gen_call,
  input logic dir_tx,
  input logic stop_seen,
  input logic bus_err
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  p_reset_idle_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_pull && !scl_pull && tx_empty && !rx_full && !addr_hit));

  p_pull_needs_hit_r4: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> addr_hit);

  p_flags_need_hit_r2: assert property (@(posedge clk) disable iff (rst)
    (hit_second || gen_call) |-> (addr_hit && !(hit_second && gen_call)));

  p_no_stretch_r9: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && no_stretch && $past(no_stretch) && $past(no_stretch, 2)) |-> !scl_pull);

  p_stretch_sda_free_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_pull) |-> !sda_pull);

  p_rxfull_rx_mode_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> (addr_hit && !dir_tx));

  p_err_excl_stop_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_err && stop_seen));

endmodule

bind i2c_target_port i2c_target_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .no_stretch (no_stretch),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .addr_hit   (addr_hit),
  .hit_second (hit_second),
  .gen_call   (gen_call),
  .dir_tx     (dir_tx),
  .stop_seen  (stop_seen),
  .bus_err    (bus_err)
);

// File: tb/tb_i2c_target_port.sv
module tb_i2c_target_port;

  localparam int Q = 5;
  localparam logic [6:0] OWN_A = 7'h2C;
  localparam logic [6:0] OWN_B = 7'h51;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic gc_enable = 1'b0, no_stretch = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_write = 1'b0, rx_read = 1'b0;
  logic scl_pull, sda_pull, tx_empty, rx_full;
  logic [7:0] rx_data;
  logic addr_hit, hit_second, gen_call, dir_tx, stop_seen, bus_err;
  logic bus_scl, bus_sda;

  assign bus_scl = ~(m_scl_low | scl_pull);
  assign bus_sda = ~(m_sda_low | sda_pull);

  i2c_target_port dut (
    .clk(clk), .rst(rst), .scl_in(bus_scl), .sda_in(bus_sda),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .own_addr_a(OWN_A), .own_addr_b(OWN_B),
    .gc_enable(gc_enable), .no_stretch(no_stretch),
    .tx_data(tx_data), .tx_write(tx_write), .tx_empty(tx_empty),
    .rx_data(rx_data), .rx_full(rx_full), .rx_read(rx_read),
    .addr_hit(addr_hit), .hit_second(hit_second), .gen_call(gen_call),
    .dir_tx(dir_tx), .stop_seen(stop_seen), .bus_err(bus_err)
  );

  int tests = 0, fails = 0;
  int stop_cnt = 0, err_cnt = 0, stretch_cnt = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst) begin
      if (stop_seen) stop_cnt++;
      if (bus_err) err_cnt++;
      if (scl_pull) stretch_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [6:0] a, input bit gc);
    if (a == 7'd0) return gc;
    return (a == OWN_A) || (a == OWN_B);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!bus_scl) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(Q);
    m_sda_low = 1'b1; cyc(Q);
    m_scl_low = 1'b1; cyc(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(Q);
    m_sda_low = 1'b0; cyc(2*Q);
  endtask

  task automatic m_wbit(input bit b);
    m_sda_low = ~b; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(2*Q);
    m_scl_low = 1'b1; cyc(Q);
  endtask

  task automatic m_rbit(output bit b);
    m_sda_low = 1'b0; cyc(Q);
    m_scl_low = 1'b0; wait_scl_high(); cyc(Q);
    b = bus_sda; cyc(Q);
    m_scl_low = 1'b1; cyc(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    acked = ~b;
  endtask

  task automatic m_rbyte(output logic [7:0] d, input bit nack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      m_rbit(b);
      d[i] = b;
    end
    m_wbit(nack);
  endtask

  task automatic rx_take();
    rx_read = 1'b1; cyc(1); rx_read = 1'b0; cyc(1);
  endtask

  task automatic tx_put(input logic [7:0] d);
    tx_data = d; tx_write = 1'b1; cyc(1); tx_write = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack, b;
    logic [7:0] d, got;
    int s0, e0, st0;
    void'($urandom(32'd4242));
    cyc(5);
    rst = 1'b0;
    cyc(3);
    // R12: reset state
    chk("R12 sda_pull", sda_pull, 0);
    chk("R12 scl_pull", scl_pull, 0);
    chk("R12 tx_empty", tx_empty, 1);
    chk("R12 rx_full", rx_full, 0);
    chk("R12 addr_hit", addr_hit, 0);

    // R2 R5 R6 R10: write to first address
    s0 = stop_cnt;
    m_start();
    m_wbyte({OWN_A, 1'b0}, ack);
    chk("R2 ack own A", ack, 1);
    chk("R2 hit_second A", hit_second, 0);
    chk("R5 dir_tx write", dir_tx, 0);
    m_wbyte(8'hB6, ack);
    chk("R6 data ack", ack, 1);
    chk("R6 rx_data", rx_data, 8'hB6);
    chk("R6 rx_full", rx_full, 1);
    rx_take();
    chk("R6 rx_full cleared", rx_full, 0);
    m_stop();
    chk("R10 stop_seen", stop_cnt - s0, 1);

    // R2: second address; R1: START clears flags
    m_start();
    chk("R1 flags cleared by START", addr_hit, 0);
    m_wbyte({OWN_B, 1'b0}, ack);
    chk("R2 ack own B", ack, 1);
    chk("R2 hit_second B", hit_second, 1);
    m_stop();

    // R3: broadcast address with enable off and on
    gc_enable = 1'b0;
    m_start();
    m_wbyte(8'h00, ack);
    chk("R3 gc disabled nack", ack, 0);
    chk("R3 gc disabled no hit", addr_hit, 0);
    m_stop();
    gc_enable = 1'b1;
    m_start();
    m_wbyte(8'h00, ack);
    chk("R3 gc enabled ack", ack, 1);
    chk("R3 gen_call flag", gen_call, 1);
    m_wbyte(8'h3C, ack);
    chk("R3 gc data", rx_data, 8'h3C);
    rx_take();
    m_stop();

    // R4: miss stays quiet for later bytes
    s0 = stop_cnt;
    m_start();
    m_wbyte({7'h13, 1'b0}, ack);
    chk("R4 miss nack", ack, 0);
    m_wbyte(8'h00, ack);
    chk("R4 miss later byte nack", ack, 0);
    chk("R4 miss no rx", rx_full, 0);
    m_stop();
    chk("R10 no stop_seen on miss", stop_cnt - s0, 0);

    // R7 R8: read two bytes, NACK, then bus stays released
    tx_put(8'hC3);
    m_start();
    m_wbyte({OWN_A, 1'b1}, ack);
    chk("R5 dir_tx read", dir_tx, 1);
    tx_put(8'h5A);
    m_rbyte(got, 1'b0);
    chk("R7 first byte", got, 8'hC3);
    m_rbyte(got, 1'b1);
    chk("R7 second byte", got, 8'h5A);
    chk("R7 tx_empty", tx_empty, 1);
    m_rbyte(got, 1'b1);
    chk("R8 released after nack", got, 8'hFF);
    m_stop();

    // R9: receive hold until rx_read
    st0 = stretch_cnt;
    m_start();
    m_wbyte({OWN_A, 1'b0}, ack);
    m_wbyte(8'h11, ack);
    for (int i = 7; i >= 0; i--) m_wbit(1'(8'h9E >> i));
    fork
      m_rbit(b);
      begin
        cyc(40);
        chk("R9 rx hold scl", scl_pull, 1);
        chk("R9 rx hold bus", bus_scl, 0);
        rx_take();
      end
    join
    chk("R9 ack after hold", b, 0);
    chk("R9 rx_data after hold", rx_data, 8'h9E);
    rx_take();
    m_stop();
    chk("R9 hold counted", (stretch_cnt - st0) > 30, 1);

    // R9: no stretch, overwrite
    no_stretch = 1'b1;
    st0 = stretch_cnt;
    m_start();
    m_wbyte({OWN_B, 1'b0}, ack);
    m_wbyte(8'h21, ack);
    m_wbyte(8'h7D, ack);
    chk("R9 no-stretch ack", ack, 1);
    chk("R9 no-stretch overwrite", rx_data, 8'h7D);
    chk("R9 no-stretch no hold", stretch_cnt - st0, 0);
    rx_take();
    m_stop();
    no_stretch = 1'b0;

    // R9: transmit hold until tx_write
    chk("R9 tx_empty before", tx_empty, 1);
    m_start();
    m_wbyte({OWN_B, 1'b1}, ack);
    fork
      m_rbyte(got, 1'b1);
      begin
        cyc(40);
        chk("R9 tx hold scl", scl_pull, 1);
        tx_put(8'hA5);
      end
    join
    chk("R9 tx byte after hold", got, 8'hA5);
    m_stop();

    // R11: STOP inside address byte
    s0 = stop_cnt; e0 = err_cnt;
    m_start();
    m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b0);
    m_stop();
    chk("R11 stop mid byte", err_cnt - e0, 1);
    chk("R11 no stop_seen", stop_cnt - s0, 0);

    // R11: START inside data byte, then recovery
    e0 = err_cnt;
    m_start();
    m_wbyte({OWN_A, 1'b0}, ack);
    m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
    m_start();
    chk("R11 start mid byte", err_cnt - e0, 1);
    m_wbyte({OWN_A, 1'b0}, ack);
    chk("R1 restart after error", ack, 1);
    m_stop();

    // R1 R10: legal repeated start between write and read
    s0 = stop_cnt; e0 = err_cnt;
    m_start();
    m_wbyte({OWN_A, 1'b0}, ack);
    m_wbyte(8'h42, ack);
    rx_take();
    tx_put(8'h99);
    m_start();
    m_wbyte({OWN_A, 1'b1}, ack);
    chk("R1 repeated start ack", ack, 1);
    m_rbyte(got, 1'b1);
    chk("R7 read after restart", got, 8'h99);
    m_stop();
    chk("R11 no error on legal restart", err_cnt - e0, 0);
    chk("R10 one stop", stop_cnt - s0, 1);

    // Random transfers
    for (int t = 0; t < 20; t++) begin
      logic [6:0] a;
      bit rw, gc, hit;
      int n;
      logic [7:0] dat [4];
      case ($urandom % 4)
        0: a = OWN_A;
        1: a = OWN_B;
        2: a = 7'd0;
        default: a = 7'($urandom % 128);
      endcase
      rw = 1'($urandom % 2);
      gc = 1'($urandom % 2);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < 4; k++) dat[k] = 8'($urandom);
      gc_enable = gc;
      hit = exp_hit(a, gc);
      s0 = stop_cnt;
      if (rw) tx_put(dat[0]);
      m_start();
      m_wbyte({a, rw}, ack);
      chk("R2 R3 R4 random addr", ack, hit);
      if (hit) begin
        chk("R5 random dir", dir_tx, rw);
        chk("R2 random second", hit_second, (a != 7'd0) && (a != OWN_A));
        if (!rw) begin
          for (int k = 0; k < n; k++) begin
            m_wbyte(dat[k], ack);
            chk("R6 random rx", rx_data, dat[k]);
            rx_take();
          end
        end else begin
          for (int k = 0; k < n; k++) begin
            if (k + 1 < n) tx_put(dat[k+1]);
            m_rbyte(got, k == n - 1);
            chk("R7 random tx", got, dat[k]);
          end
        end
      end
      m_stop();
      chk("R10 random stop", stop_cnt - s0, hit ? 1 : 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule